// File: doc/BRIEF.md
# Windowed Display RAM Address Pointer

This block produces the column and row address used while a host streams pixel data into or out of a 96-column by 64-row display memory. Software first sets a rectangular window by giving its first and last column and its first and last row. A load strobe captures these bounds and moves the pointer to the top-left corner of the window. After that, every access strobe moves the pointer to the next cell in the window.

A traversal-order input picks how the pointer steps. In row-major order it walks along the columns and wraps into the next row. In column-major order it walks down the rows and wraps into the next column. When the pointer passes the last cell of the window in either order, it returns to the window's first cell, so the same window can be written again and again without reloading it. The memory, the command decoder and the pixel data path sit outside this block.

Top module: `win_addr_ptr`

## Requirements
- R1: After reset the pointer is at column 0, row 0, and the window covers the whole memory: columns 0 to 95 and rows 0 to 63.
- R2: A load strobe captures the four bounds. On that same clock edge it places the column pointer at the first column and the row pointer at the first row.
- R3: In row-major order (`col_major` = 0), an access when the column is below the window's last column raises the column by 1 and leaves the row unchanged.
- R4: In row-major order, an access at the last column, when the row is below the last row, moves the column back to the first column and raises the row by 1.
- R5: In row-major order, an access at the last column and the last row moves both pointers back to the window's first column and first row.
- R6: In column-major order (`col_major` = 1), an access when the row is below the window's last row raises the row by 1 and leaves the column unchanged.
- R7: In column-major order, an access at the last row, when the column is below the last column, moves the row back to the first row and raises the column by 1.
- R8: In column-major order, an access at the last row and the last column moves both pointers back to the window's first cell.
- R9: When a load strobe and an access strobe arrive in the same cycle, the load takes effect and the access is dropped.
- R10: In a cycle with neither strobe, both pointers keep their values.
- R11: The traversal order is read at each access. Changing it does not move the pointer; the next access steps from the current cell in the new order.
- R12: The pointer always lies inside the window it was last loaded with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| col_major | input | 1 | Traversal order: 0 steps along columns first, 1 steps along rows first |
| win_load | input | 1 | Captures the window bounds and moves the pointer to the window start |
| col_first | input | 7 | First column of the window |
| col_last | input | 7 | Last column of the window |
| row_first | input | 6 | First row of the window |
| row_last | input | 6 | Last row of the window |
| acc_stb | input | 1 | One memory access happened; step the pointer |
| col_addr | output | 7 | Current column address |
| row_addr | output | 6 | Current row address |

## Verification
The assertions assume that every loaded window is legal. That means the first column is no larger than the last, the last column is at most 95, the first row is no larger than the last, and the last row is at most 63. One assertion checks these conditions on each load. The in-window invariant and the single-step properties depend on them. The stimulus only builds windows from pairs that are already ordered and within range. These include one-cell windows and windows placed against the top edge of the memory, so no illegal window is ever presented.

// File: rtl/win_addr_ptr.sv
module win_addr_ptr #(
  parameter int COLS = 96,
  parameter int ROWS = 64,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          col_major,
  input  logic          win_load,
  input  logic [CW-1:0] col_first,
  input  logic [CW-1:0] col_last,
  input  logic [RW-1:0] row_first,
  input  logic [RW-1:0] row_last,
  input  logic          acc_stb,
  output logic [CW-1:0] col_addr,
  output logic [RW-1:0] row_addr
);

  logic [CW-1:0] cs_q, ce_q, col_q, col_nx;
  logic [RW-1:0] rs_q, re_q, row_q, row_nx;

  wire col_end = (col_q == ce_q);
  wire row_end = (row_q == re_q);
  wire [CW-1:0] col_inc = col_end ? cs_q : col_q + CW'(1);
  wire [RW-1:0] row_inc = row_end ? rs_q : row_q + RW'(1);

  always_comb begin
    if (col_major) begin
      row_nx = row_inc;
      col_nx = row_end ? col_inc : col_q;
    end else begin
      col_nx = col_inc;
      row_nx = col_end ? row_inc : row_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= '0;
      ce_q  <= CW'(COLS - 1);
      rs_q  <= '0;
      re_q  <= RW'(ROWS - 1);
      col_q <= '0;
      row_q <= '0;
    end else if (win_load) begin
      cs_q  <= col_first;
      ce_q  <= col_last;
      rs_q  <= row_first;
      re_q  <= row_last;
      col_q <= col_first;
      row_q <= row_first;
    end else if (acc_stb) begin
      col_q <= col_nx;
      row_q <= row_nx;
    end
  end

  assign col_addr = col_q;
  assign row_addr = row_q;

  AST_LEGAL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    win_load |-> (col_first <= col_last && 32'(col_last) < COLS &&
                  row_first <= row_last && 32'(row_last) < ROWS)); // R2
  AST_LOAD_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    win_load |=> (col_addr == $past(col_first) && row_addr == $past(row_first))); // R2
  AST_LOAD_BEATS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_load && acc_stb) |=> (col_addr == $past(col_first) && row_addr == $past(row_first))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_load && !acc_stb) |=> ($stable(col_addr) && $stable(row_addr))); // R10
  AST_ROW_MAJOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !win_load && !col_major && col_addr != ce_q) |=>
      (col_addr == CW'($past(col_addr) + CW'(1)) && $stable(row_addr))); // R3
  AST_COL_MAJOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !win_load && col_major && row_addr != re_q) |=>
      (row_addr == RW'($past(row_addr) + RW'(1)) && $stable(col_addr))); // R6
  AST_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (col_addr >= cs_q && col_addr <= ce_q && row_addr >= rs_q && row_addr <= re_q)); // R12

endmodule

// File: tb/win_addr_ptr_tb_top.sv
`timescale 1ns/1ps
module win_addr_ptr_tb_top;
  localparam int CW = 7;
  localparam int RW = 6;

  typedef struct {
    int col;
    int row;
    int cs, ce, rs, re;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic col_major = 1'b0, win_load = 1'b0, acc_stb = 1'b0;
  logic [CW-1:0] col_first = '0, col_last = '0;
  logic [RW-1:0] row_first = '0, row_last = '0;
  logic [CW-1:0] col_addr;
  logic [RW-1:0] row_addr;

  int n_cmp = 0, n_bad = 0;
  exp_t q[$];
  int m_col, m_row, m_cs, m_ce, m_rs, m_re;
  int last_mode = -1;

  always #2.5 clk = ~clk;

  win_addr_ptr dut_i (
    .clk(clk), .rst_n(rst_n), .col_major(col_major), .win_load(win_load),
    .col_first(col_first), .col_last(col_last), .row_first(row_first),
    .row_last(row_last), .acc_stb(acc_stb), .col_addr(col_addr), .row_addr(row_addr)
  );

  task automatic check(string req, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit ld, bit acc, bit vm, int cf = 0, int cl = 0, int rf = 0, int rl = 0);
    exp_t e;
    @(negedge clk);
    win_load = ld; acc_stb = acc; col_major = vm;
    col_first = CW'(cf); col_last = CW'(cl); row_first = RW'(rf); row_last = RW'(rl);
    @(posedge clk);
    if (ld) begin
      e.req = acc ? "R9" : "R2";
      m_cs = cf; m_ce = cl; m_rs = rf; m_re = rl; m_col = cf; m_row = rf;
    end else if (!acc) begin
      e.req = "R10";
    end else begin
      bool_step(vm, e.req);
      if (last_mode != -1 && last_mode != int'(vm)) e.req = "R11";
      last_mode = vm;
    end
    e.col = m_col; e.row = m_row;
    e.cs = m_cs; e.ce = m_ce; e.rs = m_rs; e.re = m_re;
    q.push_back(e);
    @(negedge clk);
    win_load = 1'b0; acc_stb = 1'b0;
  endtask

  task automatic bool_step(bit vm, output string req);
    if (!vm) begin
      if (m_col != m_ce) begin m_col++; req = "R3"; end
      else if (m_row != m_re) begin m_col = m_cs; m_row++; req = "R4"; end
      else begin m_col = m_cs; m_row = m_rs; req = "R5"; end
    end else begin
      if (m_row != m_re) begin m_row++; req = "R6"; end
      else if (m_col != m_ce) begin m_row = m_rs; m_col++; req = "R7"; end
      else begin m_row = m_rs; m_col = m_cs; req = "R8"; end
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.req, int'(col_addr), e.col, "column");
        check(e.req, int'(row_addr), e.row, "row");
        check("R12", int'(col_addr >= CW'(e.cs) && col_addr <= CW'(e.ce) &&
                          row_addr >= RW'(e.rs) && row_addr <= RW'(e.re)), 1, "in-window");
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1", int'(col_addr), 0, "reset column");
    check("R1", int'(row_addr), 0, "reset row");
    m_col = 0; m_row = 0; m_cs = 0; m_ce = 95; m_rs = 0; m_re = 63;
    // R1: full default window, wrap from column 95 into row 1
    for (int i = 0; i < 100; i++) step(0, 1, 0);
    check("R1", int'(col_addr), 4, "after 100 steps column");
    check("R1", int'(row_addr), 1, "after 100 steps row");
    // R10 idle
    repeat (3) step(0, 0, 0);
    // small window, row-major then column-major, several full passes
    step(1, 0, 0, 10, 13, 5, 7);
    for (int i = 0; i < 26; i++) step(0, 1, 0);
    step(1, 0, 1, 10, 13, 5, 7);
    for (int i = 0; i < 26; i++) step(0, 1, 1);
    // R9 load and access together
    step(0, 1, 1);
    step(1, 1, 0, 40, 42, 20, 21);
    // R11 alternate orders mid-window
    for (int i = 0; i < 12; i++) step(0, 1, i % 3 == 0);
    // single-cell window
    step(1, 0, 0, 20, 20, 30, 30);
    step(0, 1, 0); step(0, 1, 1); step(0, 0, 1);
    // window against the memory top edge
    step(1, 0, 0, 93, 95, 62, 63);
    for (int i = 0; i < 8; i++) step(0, 1, 0);
    for (int i = 0; i < 8; i++) step(0, 1, 1);
    // single-column and single-row windows
    step(1, 0, 1, 0, 0, 0, 63);
    for (int i = 0; i < 66; i++) step(0, 1, 1);
    step(1, 0, 0, 0, 95, 63, 63);
    for (int i = 0; i < 98; i++) step(0, 1, 0);
    repeat (3) @(posedge clk);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule